// File: doc/BRIEF.md
# Dual-Mode Byte Port with Paced Output

This block owns an eight-line data bus and runs it in one of two modes picked at run time. In FIFO mode, bytes from an upstream valid/ready stream go straight to a downstream FIFO write handshake. Each accepted byte is placed on the lines with a one-cycle write strobe, and the lines are released between writes.

In paced mode, the same lines become a general-purpose parallel output port. Each byte from the stream is driven onto the lines and held there for a programmable number of clock cycles, set by an internal prescaler timer, before the next byte may replace it. Bytes go out strictly in arrival order. Upstream logic can send a sequence of bytes in paced mode and then return the port to FIFO mode. The mode change is deferred until the byte currently on the lines has served its full hold time.

Top module: `dual_mode_byte_port`

## Requirements
- R1: On reset the port is in FIFO mode. `lane_oe`, `fifo_wr` and `busy` are 0, and `lane_out` is 0.
- R2: In FIFO mode, a byte accepted in cycle t (`in_valid` and `in_ready` high) appears on `lane_out` in cycle t+1, with `lane_oe` all ones and `fifo_wr` high for that one cycle. In FIFO-mode cycles that follow no acceptance, `lane_oe` and `fifo_wr` are 0 and `lane_out` keeps its value.
- R3: In FIFO mode, with `mode_req` = 0, `in_ready` equals `fifo_room`. The pacing timer is held cleared, so `busy` stays 0.
- R4: In paced mode (`mode_req` = 1 once it has taken effect), accepted bytes appear on `lane_out` in acceptance order. Each appears in the cycle after it is accepted, with `lane_oe` all ones.
- R5: A byte accepted in paced mode stays on `lane_out` for exactly `divisor`+1 cycles before the next byte can appear. The divisor is the value present at acceptance; later changes do not alter a hold in progress.
- R6: `busy` is high for the `divisor` cycles that follow a paced acceptance. `in_ready` is never high while `busy` is high.
- R7: A mode change takes effect only on a clock edge at which `busy` is low. In any cycle where `mode_req` differs from the effective mode, `in_ready` is 0.
- R8: When paced mode takes effect, the next cycle shows `lane_out` = 0 and `lane_oe` all ones. When FIFO mode takes effect, the next cycle shows `lane_oe` = 0.
- R9: `fifo_wr` is never high while the port is in paced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested mode: 0 FIFO, 1 paced |
| divisor | input | DIV_W (8) | Hold length minus one for paced bytes |
| in_data | input | DATA_W (8) | Upstream byte |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Port accepts the byte this cycle |
| fifo_room | input | 1 | Downstream FIFO can take a byte |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| lane_out | output | DATA_W (8) | Value driven on the data lines |
| lane_oe | output | DATA_W (8) | Per-line output enable |
| busy | output | 1 | A paced byte is still within its hold time |

## Verification
The hardest case to reach from the ports is a mode request that flips while a paced byte is only part way through its hold. Reaching it needs a long divisor, an accepted byte, and a toggle of `mode_req` within the next few cycles. The stimulus gets there in dedicated phases: it holds the divisor large, keeps the stream valid, and flips `mode_req` at random per cycle. It also changes the divisor during holds, to show that the divisor latched at acceptance still governs the hold. A behavioural model in the bench tracks the effective mode and remaining hold as plain integers and is compared against every output on every clock.

// File: rtl/dmbp_pkg.sv
package dmbp_pkg;
  typedef enum logic {
    PORT_FIFO  = 1'b0,
    PORT_PACED = 1'b1
  } port_mode_e;
endpackage

// File: rtl/dmbp_pace_timer.sv
module dmbp_pace_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             idle
);
  logic [DIV_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign idle = (remain == '0);

  // R5: a running hold counts down by one per cycle
  assert_hold_countdown_R5: assert property (@(posedge clk) disable iff (rst)
    (remain != '0 && !clear && !load) |=> (remain == $past(remain) - 1'b1));

  // R5: a load is only possible when no hold is running
  assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> idle);
endmodule

// File: rtl/dmbp_mode_ctrl.sv
module dmbp_mode_ctrl
  import dmbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_req,
  input  logic       timer_idle,
  output port_mode_e mode_cur,
  output port_mode_e mode_next,
  output logic       switch_now
);
  assign mode_next  = mode_req ? PORT_PACED : PORT_FIFO;
  assign switch_now = (mode_next != mode_cur) && timer_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_cur <= PORT_FIFO;
    end else if (switch_now) begin
      mode_cur <= mode_next;
    end
  end

  // R7: the effective mode only moves while no hold is running
  assert_switch_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_cur != $past(mode_cur)) |-> $past(timer_idle));
endmodule

// File: rtl/dmbp_lane_driver.sv
module dmbp_lane_driver
  import dmbp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  port_mode_e        mode_cur,
  input  port_mode_e        mode_next,
  input  logic              switch_now,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] lane_out,
  output logic [DATA_W-1:0] lane_oe,
  output logic              fifo_wr
);
  localparam logic [DATA_W-1:0] ALL_ON = {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_out <= '0;
      lane_oe  <= '0;
      fifo_wr  <= 1'b0;
    end else if (switch_now) begin
      fifo_wr <= 1'b0;
      if (mode_next == PORT_PACED) begin
        lane_out <= '0;
        lane_oe  <= ALL_ON;
      end else begin
        lane_oe <= '0;
      end
    end else if (mode_cur == PORT_FIFO) begin
      if (accept) begin
        lane_out <= in_data;
        lane_oe  <= ALL_ON;
        fifo_wr  <= 1'b1;
      end else begin
        lane_oe <= '0;
        fifo_wr <= 1'b0;
      end
    end else begin
      fifo_wr <= 1'b0;
      if (accept) begin
        lane_out <= in_data;
      end
    end
  end

  // R9: no FIFO write strobe while paced mode is in effect
  assert_no_wr_paced_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == PORT_PACED) |-> !fifo_wr);

  // R2: a write strobe always comes with the lines enabled
  assert_wr_drives_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (lane_oe == ALL_ON));
endmodule

// File: rtl/dual_mode_byte_port.sv
module dual_mode_byte_port
  import dmbp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              fifo_room,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] lane_out,
  output logic [DATA_W-1:0] lane_oe,
  output logic              busy
);
  port_mode_e mode_cur;
  port_mode_e mode_next;
  logic       switch_now;
  logic       timer_idle;
  logic       accept;
  logic       settled;

  dmbp_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_req   (mode_req),
    .timer_idle (timer_idle),
    .mode_cur   (mode_cur),
    .mode_next  (mode_next),
    .switch_now (switch_now)
  );

  assign settled  = (mode_next == mode_cur);
  assign in_ready = settled &&
                    ((mode_cur == PORT_FIFO) ? fifo_room : timer_idle);
  assign accept   = in_valid && in_ready;

  dmbp_pace_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    ((mode_cur == PORT_FIFO) || switch_now),
    .load     (accept && (mode_cur == PORT_PACED)),
    .load_val (divisor),
    .idle     (timer_idle)
  );

  dmbp_lane_driver #(.DATA_W(DATA_W)) u_lanes (
    .clk        (clk),
    .rst        (rst),
    .mode_cur   (mode_cur),
    .mode_next  (mode_next),
    .switch_now (switch_now),
    .accept     (accept),
    .in_data    (in_data),
    .lane_out   (lane_out),
    .lane_oe    (lane_oe),
    .fifo_wr    (fifo_wr)
  );

  assign busy = !timer_idle;

  // R6: never ready while a paced byte is being held
  assert_ready_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !busy);

  // R5: the lines do not move at an edge where a hold was running
  assert_lanes_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(lane_out));

  // R3: FIFO mode keeps the pacing timer cleared
  assert_fifo_timer_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == PORT_FIFO) |-> !busy);
endmodule

// File: tb/dual_mode_byte_port_test.sv
module dual_mode_byte_port_test;
  localparam int DW = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_req = 1'b0;
  logic [VW-1:0] divisor = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          fifo_room = 1'b0;
  logic          fifo_wr;
  logic [DW-1:0] lane_out;
  logic [DW-1:0] lane_oe;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          m_paced = 0;
  int          m_hold  = 0;
  logic [7:0]  m_out   = 8'h00;
  logic [7:0]  m_oe    = 8'h00;
  bit          m_wr    = 0;
  logic [7:0]  next_byte = 8'h01;

  always #10 clk = ~clk;

  dual_mode_byte_port #(.DATA_W(DW), .DIV_W(VW)) uut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .divisor(divisor),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .fifo_room(fifo_room), .fifo_wr(fifo_wr), .lane_out(lane_out),
    .lane_oe(lane_oe), .busy(busy)
  );

  function automatic bit model_ready();
    if (mode_req != m_paced) return 0;
    if (!m_paced) return fifo_room;
    return (m_hold == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_paced = 0; m_hold = 0; m_out = 8'h00; m_oe = 8'h00; m_wr = 0;
    end else begin
      automatic bit rdy = model_ready();
      automatic bit acc = rdy && in_valid;
      if (mode_req != m_paced && m_hold == 0) begin
        m_paced = mode_req;
        m_wr = 0;
        if (m_paced) begin m_out = 8'h00; m_oe = 8'hFF; end
        else m_oe = 8'h00;
      end else if (!m_paced) begin
        m_hold = 0;
        if (acc) begin m_out = in_data; m_oe = 8'hFF; m_wr = 1; end
        else begin m_oe = 8'h00; m_wr = 0; end
      end else begin
        m_wr = 0;
        if (acc) begin m_out = in_data; m_hold = int'(divisor); end
        else if (m_hold > 0) m_hold = m_hold - 1;
      end
      if (acc) next_byte = next_byte + 8'd1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_state();
    check(lane_out == m_out, "R2 R4 R5 R8 lane_out", lane_out, m_out);
    check(lane_oe == m_oe, "R1 R2 R8 lane_oe", lane_oe, m_oe);
    check(fifo_wr == m_wr, "R2 R9 fifo_wr", fifo_wr, m_wr);
    check(busy == (m_hold != 0), "R3 R6 busy", busy, m_hold != 0);
  endtask

  // one cycle: compare at negedge, drive new inputs, compare ready
  task automatic step(input int p_valid, input int p_room, input int p_flip,
                      input bit base_mode, input int div_lo, input int div_hi);
    @(negedge clk);
    compare_state();
    in_valid  = ($urandom_range(99) < p_valid);
    fifo_room = ($urandom_range(99) < p_room);
    mode_req  = ($urandom_range(99) < p_flip) ? !base_mode : base_mode;
    divisor   = VW'($urandom_range(div_hi, div_lo));
    in_data   = next_byte;
    #2;
    check(in_ready == model_ready(), "R3 R6 R7 in_ready", in_ready, model_ready());
  endtask

  initial begin
    void'($urandom(11));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(lane_oe == 8'h00, "R1 oe after reset", lane_oe, 0);
    check(lane_out == 8'h00, "R1 lanes after reset", lane_out, 0);
    check(fifo_wr == 1'b0, "R1 wr after reset", fifo_wr, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    rst = 1'b0;
    // FIFO traffic, varying room and valid (R2, R3)
    repeat (300) step(70, 60, 0, 1'b0, 0, 255);
    // enter paced mode, short divisors (R4, R5, R8)
    repeat (200) step(80, 50, 0, 1'b1, 0, 2);
    // longer divisors, divisor changing during holds (R5, R6)
    repeat (400) step(90, 50, 0, 1'b1, 3, 9);
    // mode request flipping mid-hold (R7)
    repeat (1500) step(85, 50, 15, 1'b1, 4, 12);
    // back to FIFO (R8, R9)
    repeat (300) step(70, 70, 0, 1'b0, 0, 20);
    // mixed flipping around FIFO base
    repeat (1500) step(75, 55, 20, 1'b0, 0, 6);
    // continuous stream, divisor zero in paced mode (R5 edge)
    repeat (200) step(100, 100, 0, 1'b1, 0, 0);
    // reset mid-traffic restores R1 state
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check(lane_oe == 8'h00, "R1 oe after second reset", lane_oe, 0);
    check(busy == 1'b0, "R1 busy after second reset", busy, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule